// File: doc/BRIEF.md
# 8-bit ALU with Selective Status-Flag Update

This combinational arithmetic and logic unit serves a small register-to-register processor core. It takes a first register operand and a second operand that is either another register or an immediate constant. It also takes the current carry and zero bits from the status register and a 4-bit operation code. From these it forms an 8-bit result, five candidate flag values, a mask naming the flags the operation owns, and a strobe that says whether the result is written back.

Each operation owns a fixed subset of the zero, carry, negative, overflow and half-carry flags. The status register outside the unit writes only the masked bits and keeps the others. This lets increment and decrement be used as loop counters without disturbing a pending carry. It also lets the borrow-chained subtract and compare keep a zero indication across the bytes of a multi-byte quantity. Compares produce flags only, and their result strobe stays low.

Top module: `aluFlagUnit`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, CPC=5, AND=6, OR=7, XOR=8, ANDN=9, COM=10, NEG=11, INC=12, DEC=13, CLR=14, SET=15. ADD, ADC and SUB return A+B, A+B+carryIn and A−B respectively. ADD and SUB ignore carryIn.
- R2: The mask `flagWe` and the flag vector `flagOut` share one layout: bit 0 is Z, bit 1 C, bit 2 N, bit 3 V and bit 4 H. A flag whose mask bit is 0 reads 0 on `flagOut`. Add and subtract forms, including NEG, set all five mask bits.
- R3: V is signed two's-complement overflow. H is the carry out of bit 3 for addition, or the borrow into bit 4 for subtraction. C is the carry out of bit 7 for addition, or the borrow for subtraction. N is result bit 7.
- R4: SBC returns A−B−carryIn. For SBC and CPC, Z is 1 only when the result is zero and zeroIn is 1.
- R5: CMP and CPC produce the flags of SUB and SBC respectively, with `resultWe` low. Every other operation drives `resultWe` high.
- R6: AND, OR, XOR and ANDN (A AND NOT B) set only the Z, N and V mask bits (mask 5'b01101), and V reads 0.
- R7: COM returns NOT A with C forced to 1, V 0, and mask 5'b01111.
- R8: NEG returns 0−A, with C equal to 1 exactly when the result is nonzero.
- R9: INC and DEC return A+1 and A−1 with mask 5'b01101. carryIn has no effect on them, and V marks 0x7F→0x80 and 0x80→0x7F.
- R10: CLR returns 0 with Z=1 and mask 5'b01101. SET returns 0xFF with an all-zero mask.
- R11: When `useImm` is 1, `immK` replaces `regB` as the second operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see R1) |
| regA | input | 8 | First register operand |
| regB | input | 8 | Second register operand |
| immK | input | 8 | Immediate constant |
| useImm | input | 1 | Select immK instead of regB |
| carryIn | input | 1 | Current carry flag |
| zeroIn | input | 1 | Current zero flag, for chained operations |
| result | output | 8 | Operation result |
| flagOut | output | 5 | Flag values {H,V,N,C,Z}, masked |
| flagWe | output | 5 | Flag write mask {H,V,N,C,Z} |
| resultWe | output | 1 | Result is to be written back |

## Verification
The unit holds no state, so an error in the decoded strobes shows up at the ports within the same evaluation. One example is a wrong carry-use or operand-force bit. Another is a mask bit left set on increment, which would let the status register overwrite a carry the program still needs. Both show as a wrong result, flag or mask on the operation itself. The vectors target the points where the decode is most likely to be wrong. These include the signed-overflow boundaries 0x7F/0x80, the nibble carry and borrow edges, and a zero result with the chained zero flag both set and clear. They also include NEG of 0 and 0x80 and carryIn held at 1 on operations that must ignore it.

// File: rtl/aluFlagPkg.sv
package aluFlagPkg;

  localparam int FLAG_W = 5;
  localparam int FLAG_Z = 0;
  localparam int FLAG_C = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_H = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_CPC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_ANDN = 4'd9,
    OP_COM  = 4'd10,
    OP_NEG  = 4'd11,
    OP_INC  = 4'd12,
    OP_DEC  = 4'd13,
    OP_CLR  = 4'd14,
    OP_SET  = 4'd15
  } aluOpE;

  typedef enum logic [1:0] {
    PATH_ARITH = 2'd0,
    PATH_LOGIC = 2'd1,
    PATH_COM   = 2'd2,
    PATH_CONST = 2'd3
  } pathE;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_ANDN = 2'd3
  } logicFnE;

  localparam logic [FLAG_W-1:0] MASK_ALL   = 5'b11111;
  localparam logic [FLAG_W-1:0] MASK_ZNV   = 5'b01101;
  localparam logic [FLAG_W-1:0] MASK_ZCNV  = 5'b01111;
  localparam logic [FLAG_W-1:0] MASK_NONE  = 5'b00000;

  typedef struct packed {
    pathE              path;
    logic              subtract;
    logic              useCarry;
    logic              zeroA;
    logic              bFromA;
    logic              bIsOne;
    logicFnE           logicFn;
    logic              constOnes;
    logic              chainZ;
    logic              keepResult;
    logic [FLAG_W-1:0] flagMask;
  } aluStrobeT;

endpackage

// File: rtl/aluFlagCtrl.sv
module aluFlagCtrl
  import aluFlagPkg::*;
(
  input  logic [3:0] opSel,
  output aluStrobeT  strobe
);

  aluOpE opCode;
  assign opCode = aluOpE'(opSel);

  always_comb begin
    strobe            = '0;
    strobe.path       = PATH_ARITH;
    strobe.logicFn    = LG_AND;
    strobe.keepResult = 1'b1;
    strobe.flagMask   = MASK_ALL;
    unique case (opCode)
      OP_ADD: ;
      OP_ADC: strobe.useCarry = 1'b1;
      OP_SUB: strobe.subtract = 1'b1;
      OP_SBC: begin
        strobe.subtract = 1'b1;
        strobe.useCarry = 1'b1;
        strobe.chainZ   = 1'b1;
      end
      OP_CMP: begin
        strobe.subtract   = 1'b1;
        strobe.keepResult = 1'b0;
      end
      OP_CPC: begin
        strobe.subtract   = 1'b1;
        strobe.useCarry   = 1'b1;
        strobe.chainZ     = 1'b1;
        strobe.keepResult = 1'b0;
      end
      OP_AND, OP_OR, OP_XOR, OP_ANDN: begin
        strobe.path     = PATH_LOGIC;
        strobe.flagMask = MASK_ZNV;
        case (opCode)
          OP_OR:   strobe.logicFn = LG_OR;
          OP_XOR:  strobe.logicFn = LG_XOR;
          OP_ANDN: strobe.logicFn = LG_ANDN;
          default: strobe.logicFn = LG_AND;
        endcase
      end
      OP_COM: begin
        strobe.path     = PATH_COM;
        strobe.flagMask = MASK_ZCNV;
      end
      OP_NEG: begin
        strobe.subtract = 1'b1;
        strobe.zeroA    = 1'b1;
        strobe.bFromA   = 1'b1;
      end
      OP_INC: begin
        strobe.bIsOne   = 1'b1;
        strobe.flagMask = MASK_ZNV;
      end
      OP_DEC: begin
        strobe.subtract = 1'b1;
        strobe.bIsOne   = 1'b1;
        strobe.flagMask = MASK_ZNV;
      end
      OP_CLR: begin
        strobe.path     = PATH_CONST;
        strobe.flagMask = MASK_ZNV;
      end
      OP_SET: begin
        strobe.path      = PATH_CONST;
        strobe.constOnes = 1'b1;
        strobe.flagMask  = MASK_NONE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/aluFlagDatapath.sv
module aluFlagDatapath
  import aluFlagPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobeT          strobe,
  input  logic [DATA_W-1:0]  regA,
  input  logic [DATA_W-1:0]  operandB,
  input  logic               carryIn,
  input  logic               zeroIn,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_W-1:0]  rawFlags
);

  localparam int WIDE   = DATA_W + 1;
  localparam int HALF   = DATA_W / 2;
  localparam int HWIDE  = HALF + 1;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] opX;
  logic [DATA_W-1:0] opY;
  logic              cinEff;
  logic [WIDE-1:0]   wideOut;
  logic [HWIDE-1:0]  lowOut;
  logic [DATA_W-1:0] logicOut;
  logic              overflow;

  assign opX    = strobe.zeroA  ? '0 : regA;
  assign opY    = strobe.bFromA ? regA
                : strobe.bIsOne ? DATA_W'(1) : operandB;
  assign cinEff = strobe.useCarry & carryIn;

  // One adder serves both directions; bit DATA_W is carry or borrow,
  // bit HALF of the low slice is the nibble carry or borrow.
  always_comb begin
    if (strobe.subtract) begin
      wideOut = {1'b0, opX} - {1'b0, opY} - WIDE'(cinEff);
      lowOut  = {1'b0, opX[HALF-1:0]} - {1'b0, opY[HALF-1:0]} - HWIDE'(cinEff);
    end else begin
      wideOut = {1'b0, opX} + {1'b0, opY} + WIDE'(cinEff);
      lowOut  = {1'b0, opX[HALF-1:0]} + {1'b0, opY[HALF-1:0]} + HWIDE'(cinEff);
    end
  end

  always_comb begin
    unique case (strobe.logicFn)
      LG_AND:  logicOut = regA & operandB;
      LG_OR:   logicOut = regA | operandB;
      LG_XOR:  logicOut = regA ^ operandB;
      default: logicOut = regA & ~operandB;
    endcase
  end

  always_comb begin
    if (strobe.subtract)
      overflow = (opX[MSB] & ~opY[MSB] & ~wideOut[MSB]) |
                 (~opX[MSB] & opY[MSB] & wideOut[MSB]);
    else
      overflow = (opX[MSB] & opY[MSB] & ~wideOut[MSB]) |
                 (~opX[MSB] & ~opY[MSB] & wideOut[MSB]);
  end

  always_comb begin
    rawFlags = '0;
    unique case (strobe.path)
      PATH_ARITH: begin
        result           = wideOut[DATA_W-1:0];
        rawFlags[FLAG_C] = wideOut[DATA_W];
        rawFlags[FLAG_V] = overflow;
        rawFlags[FLAG_H] = lowOut[HALF];
      end
      PATH_LOGIC: result = logicOut;
      PATH_COM: begin
        result           = ~regA;
        rawFlags[FLAG_C] = 1'b1;
      end
      default: result = strobe.constOnes ? '1 : '0;
    endcase
    rawFlags[FLAG_N] = result[MSB];
    rawFlags[FLAG_Z] = (result == '0) & (~strobe.chainZ | zeroIn);
  end

endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import aluFlagPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] immK,
  input  logic              useImm,
  input  logic              carryIn,
  input  logic              zeroIn,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        flagOut,
  output logic [4:0]        flagWe,
  output logic              resultWe
);

  aluStrobeT         strobe;
  logic [DATA_W-1:0] operandB;
  logic [FLAG_W-1:0] rawFlags;

  assign operandB = useImm ? immK : regB;

  aluFlagCtrl i_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  aluFlagDatapath #(.DATA_W(DATA_W)) i_dp (
    .strobe   (strobe),
    .regA     (regA),
    .operandB (operandB),
    .carryIn  (carryIn),
    .zeroIn   (zeroIn),
    .result   (result),
    .rawFlags (rawFlags)
  );

  assign flagWe   = strobe.flagMask;
  assign flagOut  = rawFlags & strobe.flagMask;
  assign resultWe = strobe.keepResult;

endmodule

// File: rtl/aluFlagChecker.sv
module aluFlagChecker
  import aluFlagPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] regA,
  input logic              zeroIn,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        flagOut,
  input logic [4:0]        flagWe,
  input logic              resultWe
);

  always_comb begin
    // R2: unmasked flags read zero
    a_r2_masked_zero: assert ((flagOut & ~flagWe) == 5'b0);
    // R5: compares never write back
    a_r5_cmp_no_write: assert (resultWe == !(opSel == OP_CMP || opSel == OP_CPC));
    // R4: chained zero cannot appear from a cleared zero input
    a_r4_chain_z: assert (!((opSel == OP_SBC || opSel == OP_CPC) && !zeroIn) || !flagOut[FLAG_Z]);
    // R6: logical ops clear overflow and own only Z,N,V
    a_r6_logic_v: assert (!(opSel inside {OP_AND, OP_OR, OP_XOR, OP_ANDN})
                          || (!flagOut[FLAG_V] && flagWe == 5'b01101));
    // R7: complement always reports carry
    a_r7_com_carry: assert (opSel != OP_COM || (flagOut[FLAG_C] && result == ~regA));
    // R8: negate carry tracks nonzero result
    a_r8_neg_carry: assert (opSel != OP_NEG || (flagOut[FLAG_C] == (result != '0)));
    // R9: increment and decrement leave carry untouched
    a_r9_incdec_no_carry: assert (!(opSel == OP_INC || opSel == OP_DEC) || !flagWe[FLAG_C]);
    // R10: set-register writes all ones and touches no flag
    a_r10_set_quiet: assert (opSel != OP_SET || (flagWe == 5'b0 && result == '1));
  end

endmodule

bind aluFlagUnit aluFlagChecker #(.DATA_W(DATA_W)) u_aluFlagChecker (
  .opSel    (opSel),
  .regA     (regA),
  .zeroIn   (zeroIn),
  .result   (result),
  .flagOut  (flagOut),
  .flagWe   (flagWe),
  .resultWe (resultWe)
);

// File: tb/test_aluFlagUnit.sv
`timescale 1ns/1ps
module test_aluFlagUnit;

  localparam int NVEC = 27;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] regA = '0, regB = '0, immK = '0;
  logic       useImm = 1'b0, carryIn = 1'b0, zeroIn = 1'b0;
  logic [7:0] result;
  logic [4:0] flagOut, flagWe;
  logic       resultWe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aluFlagUnit i_aluFlagUnit (
    .opSel(opSel), .regA(regA), .regB(regB), .immK(immK), .useImm(useImm),
    .carryIn(carryIn), .zeroIn(zeroIn), .result(result), .flagOut(flagOut),
    .flagWe(flagWe), .resultWe(resultWe)
  );

  // {op, A, B, carryIn, zeroIn, expResult, expFlags{H,V,N,C,Z}, expMask, expResultWe}
  localparam logic [40:0] VEC [NVEC] = '{
    {4'd0,  8'h0F, 8'h01, 1'b1, 1'b0, 8'h10, 5'b10000, 5'b11111, 1'b1},
    {4'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 5'b11100, 5'b11111, 1'b1},
    {4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 5'b10011, 5'b11111, 1'b1},
    {4'd1,  8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 5'b00000, 5'b11111, 1'b1},
    {4'd2,  8'h10, 8'h01, 1'b1, 1'b0, 8'h0F, 5'b10000, 5'b11111, 1'b1},
    {4'd2,  8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 5'b11000, 5'b11111, 1'b1},
    {4'd2,  8'h01, 8'h02, 1'b0, 1'b0, 8'hFF, 5'b10110, 5'b11111, 1'b1},
    {4'd3,  8'h05, 8'h05, 1'b0, 1'b1, 8'h00, 5'b00001, 5'b11111, 1'b1},
    {4'd3,  8'h05, 8'h05, 1'b0, 1'b0, 8'h00, 5'b00000, 5'b11111, 1'b1},
    {4'd3,  8'h05, 8'h04, 1'b1, 1'b1, 8'h00, 5'b00001, 5'b11111, 1'b1},
    {4'd4,  8'h03, 8'h05, 1'b0, 1'b0, 8'hFE, 5'b10110, 5'b11111, 1'b0},
    {4'd5,  8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 5'b10110, 5'b11111, 1'b0},
    {4'd6,  8'hF0, 8'h3C, 1'b0, 1'b0, 8'h30, 5'b00000, 5'b01101, 1'b1},
    {4'd7,  8'h80, 8'h01, 1'b0, 1'b0, 8'h81, 5'b00100, 5'b01101, 1'b1},
    {4'd8,  8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00, 5'b00001, 5'b01101, 1'b1},
    {4'd9,  8'hFF, 8'h0F, 1'b0, 1'b0, 8'hF0, 5'b00100, 5'b01101, 1'b1},
    {4'd10, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 5'b00110, 5'b01111, 1'b1},
    {4'd10, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 5'b00011, 5'b01111, 1'b1},
    {4'd11, 8'h01, 8'h00, 1'b0, 1'b0, 8'hFF, 5'b10110, 5'b11111, 1'b1},
    {4'd11, 8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 5'b01110, 5'b11111, 1'b1},
    {4'd11, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 5'b00001, 5'b11111, 1'b1},
    {4'd12, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 5'b01100, 5'b01101, 1'b1},
    {4'd12, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 5'b00001, 5'b01101, 1'b1},
    {4'd13, 8'h80, 8'h00, 1'b1, 1'b0, 8'h7F, 5'b01000, 5'b01101, 1'b1},
    {4'd13, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 5'b00001, 5'b01101, 1'b1},
    {4'd14, 8'h55, 8'h55, 1'b0, 1'b0, 8'h00, 5'b00001, 5'b01101, 1'b1},
    {4'd15, 8'h12, 8'h34, 1'b1, 1'b1, 8'hFF, 5'b00000, 5'b00000, 1'b1}
  };

  function automatic string reqForOp(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2: return "R1";
      4'd3:             return "R4";
      4'd4, 4'd5:       return "R5";
      4'd10:            return "R7";
      4'd11:            return "R8";
      4'd12, 4'd13:     return "R9";
      4'd14, 4'd15:     return "R10";
      default:          return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] actual, input logic [7:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ui, input logic [7:0] k, input logic ci, input logic zi);
    @(negedge clk);
    opSel = op; regA = a; regB = b; useImm = ui; immK = k; carryIn = ci; zeroIn = zi;
    #2;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Idle state: ADD of zeros, result 0, Z only, full mask (R1, R2)
    drive(4'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R1", "idle result", result, 8'h00);
    check("R2", "idle flags", {3'b0, flagOut}, 8'h01);
    check("R2", "idle mask", {3'b0, flagWe}, 8'h1F);

    for (int i = 0; i < NVEC; i++) begin
      logic [40:0] v;
      v = VEC[i];
      drive(v[40:37], v[36:29], v[28:21], 1'b0, 8'hA5, v[20], v[19]);
      check(reqForOp(v[40:37]), $sformatf("vec %0d result", i), result, v[18:11]);
      check((v[40:37] <= 4'd2) ? "R3" : reqForOp(v[40:37]),
            $sformatf("vec %0d flags", i), {3'b0, flagOut}, {3'b0, v[10:6]});
      check("R2", $sformatf("vec %0d mask", i), {3'b0, flagWe}, {3'b0, v[5:1]});
      check("R5", $sformatf("vec %0d resultWe", i), {7'b0, resultWe}, {7'b0, v[0]});
    end

    // R11: immediate replaces regB
    drive(4'd2, 8'h10, 8'h99, 1'b1, 8'h01, 1'b0, 1'b0);
    check("R11", "SUB imm result", result, 8'h0F);
    drive(4'd4, 8'h42, 8'h00, 1'b1, 8'h42, 1'b0, 1'b0);
    check("R11", "CMP imm equal flags", {3'b0, flagOut}, 8'h01);
    drive(4'd7, 8'h00, 8'hFF, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R11", "OR imm zero", result, 8'h00);
    // R9: carry input has no effect on DEC result
    drive(4'd13, 8'h10, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R9", "DEC carry ignored", result, 8'h0F);
    // R4: SBC with borrow chained, nonzero result clears Z
    drive(4'd3, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1);
    check("R4", "SBC borrow result", result, 8'hFF);
    check("R4", "SBC borrow flags", {3'b0, flagOut}, 8'h16);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule